// File: doc/BRIEF.md
# Network Controller Register File

This block holds the sixty-four 16-bit host-visible registers of a bus-mastering Ethernet controller. A host slave port reaches it through a word address, separate read and write strobes and 16-bit data. Most locations are plain storage. A minority follow their own write rules: the command register with its reset-mode gate, configuration registers that accept writes only in reset mode, fields that software cannot write, a write-one-to-clear interrupt status register, tally counters that store the inverse of what is written, and ring pointers whose low bits are forced to zero to keep them aligned.

Neighbouring engines use two outputs of the block. The first is a set of single-cycle command strobes: transmit, load the address filter, fetch a receive resource, start the timer and stop the timer. The second is a level interrupt. Those engines report back through a status-set vector that ORs into the interrupt status register, and through two completion inputs that clear the transmit and filter-load command bits. Reads are combinational by default. A parameter can register them instead.

Top module: `nrf_regbank`

## Requirements
- R1: After hardware reset these registers read as follows. Command (address 0x00) is 0x0094, which is reset mode, timer stopped and receiver off. Transmit control (0x03) is 0x0101. Receive control (0x02) is 0x0020. End-of-buffer count (0x13) is 0x02F8. Revision (0x28) is 0x0004. Every other register, including mask (0x04), status (0x05) and filter enable (0x25), is 0.
- R2: A command write ORs its data into the command register through the mask 0x03BF. Command bits are: halt bit0, transmit bit1, receiver-off bit2, receiver-on bit3, timer-stop bit4, timer-start bit5, soft reset bit7, resource fetch bit8, filter load bit9. Bits 1, 9, 8, 5 and 4 of an accepted write raise tx_go, cam_load_go, rsrc_fetch_go, timer_start_go and timer_stop_go for exactly one cycle, in the cycle after the write. Bit 8 never reads back as 1.
- R3: While command bit7 is set, a command write with bit7 clear only clears bit7. It changes no other bit and raises no strobe.
- R4: An accepted command write with bit7 set clears bits 9, 8, 1 and 0, then sets bits 7 and 2.
- R5: These clears are applied in order: bit2 written clears bit3, bit3 written clears bit2, bit4 written clears bit5, bit5 written clears bit4. They happen before the soft-reset action of R4.
- R6: Data configuration (0x01) takes data AND 0xBFFF, and the second configuration register (0x3F) takes data AND 0xF017. Both accept the write only while command bit7 is set. At any other time the write is dropped.
- R7: Transmit control keeps only written bits 15:12. Receive control keeps only written bits 15:5. The interrupt mask keeps written bits 14:0 and bit15 reads 0.
- R8: Writing status (0x05) clears each bit written 1. status_set ORs into status in the same cycle and wins over a clear of the same bit.
- R9: When a status write clears bit5 (buffers exhausted) while it is set, rsrc_fetch_go pulses in the next cycle. Writing bit5 while it is already clear gives no pulse.
- R10: irq is 1 exactly when some bit is set in both mask and status. It follows a change of either register in the cycle that register changes.
- R11: The tally registers 0x2C, 0x2D and 0x2E store the bitwise inverse of the written data.
- R12: Ring pointer registers 0x15 to 0x18 store data with bit0 cleared when data configuration bit5 is 0, and with bits 1:0 cleared when it is 1.
- R13: Writes to 0x22, 0x23, 0x24, 0x28 and 0x2F are ignored. The three filter-port registers read 0.
- R14: tx_done clears command bit1 and cam_done clears command bit9. Each takes priority over a command write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| addr | input | ADDR_W | Register word address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; rdata is 0 when low |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| status_set | input | DATA_W | Bits to set in interrupt status |
| tx_done | input | 1 | Transmit finished; clears command bit1 |
| cam_done | input | 1 | Filter load finished; clears command bit9 |
| irq | output | 1 | Level interrupt |
| tx_go | output | 1 | Transmit strobe |
| cam_load_go | output | 1 | Address filter load strobe |
| rsrc_fetch_go | output | 1 | Receive resource fetch strobe |
| timer_start_go | output | 1 | Timer start strobe |
| timer_stop_go | output | 1 | Timer stop strobe |

## Verification
The hardest case to reach is a configuration or ring-pointer write whose result depends on earlier mode changes. Reaching it takes three steps: the command register is taken out of reset mode, then put back into it with a soft reset, then taken out again. Only then do the pointer writes see the new data-width bit. The directed sequence walks that path on purpose, in both data widths. A status write and a status_set that hit the same bit in the same cycle are also forced directly. After that, a long stretch of random traffic covers every address, sparse status-set pulses and completion pulses, and compares strobes and irq against the bench model on every clock.

// File: rtl/nrf_pkg.sv
package nrf_pkg;

   // register word addresses decoded by host software
   localparam int ADR_CMD   = 'h00;
   localparam int ADR_DCFG  = 'h01;
   localparam int ADR_RXCTL = 'h02;
   localparam int ADR_TXCTL = 'h03;
   localparam int ADR_IMASK = 'h04;
   localparam int ADR_ISTAT = 'h05;
   localparam int ADR_EOB   = 'h13;
   localparam int ADR_RGBEG = 'h15;
   localparam int ADR_RGEND = 'h16;
   localparam int ADR_RGRD  = 'h17;
   localparam int ADR_RGWR  = 'h18;
   localparam int ADR_PRT2  = 'h22;
   localparam int ADR_PRT1  = 'h23;
   localparam int ADR_PRT0  = 'h24;
   localparam int ADR_REV   = 'h28;
   localparam int ADR_TCRC  = 'h2C;
   localparam int ADR_TALN  = 'h2D;
   localparam int ADR_TMIS  = 'h2E;
   localparam int ADR_DIAG  = 'h2F;
   localparam int ADR_DCFG2 = 'h3F;

   // command bit positions
   localparam int CB_HALT   = 0;
   localparam int CB_TX     = 1;
   localparam int CB_RXOFF  = 2;
   localparam int CB_RXON   = 3;
   localparam int CB_TSTOP  = 4;
   localparam int CB_TSTART = 5;
   localparam int CB_SRST   = 7;
   localparam int CB_RFETCH = 8;
   localparam int CB_CAMLD  = 9;

   localparam int DCFG_WIDE = 5;
   localparam int IS_BUFEX  = 5;

   localparam logic [15:0] CMD_WMASK  = 16'h03BF;
   localparam logic [15:0] CMD_RSTVAL = 16'h0094;
   localparam logic [15:0] IMR_WMASK  = 16'h7FFF;

   typedef struct packed {
      logic tx;
      logic camld;
      logic rfetch;
      logic tstart;
      logic tstop;
   } cmd_pulse_t;

   // slots held by dedicated units, not by the generic store
   function automatic logic held_elsewhere(int idx);
      return (idx == ADR_CMD) || (idx == ADR_IMASK) || (idx == ADR_ISTAT);
   endfunction

   function automatic logic [15:0] slot_reset(int idx);
      case (idx)
         ADR_TXCTL: return 16'h0101;
         ADR_RXCTL: return 16'h0020;
         ADR_EOB:   return 16'h02F8;
         ADR_REV:   return 16'h0004;
         default:   return 16'h0000;
      endcase
   endfunction

   function automatic logic [15:0] slot_write(int idx, logic [15:0] cur,
                                              logic [15:0] wd, logic in_rst,
                                              logic wide);
      case (idx)
         ADR_DCFG:  return in_rst ? (wd & 16'hBFFF) : cur;
         ADR_DCFG2: return in_rst ? (wd & 16'hF017) : cur;
         ADR_TXCTL: return wd & 16'hF000;
         ADR_RXCTL: return wd & 16'hFFE0;
         ADR_RGBEG, ADR_RGEND, ADR_RGRD, ADR_RGWR:
            return wide ? (wd & 16'hFFFC) : (wd & 16'hFFFE);
         ADR_TCRC, ADR_TALN, ADR_TMIS: return ~wd;
         ADR_PRT2, ADR_PRT1, ADR_PRT0, ADR_REV, ADR_DIAG: return cur;
         default:   return wd;
      endcase
   endfunction

endpackage

// File: rtl/nrf_cmd_unit.sv
module nrf_cmd_unit
   import nrf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [15:0] wd,
   input  logic        tx_done,
   input  logic        cam_done,
   output logic [15:0] cmd_q,
   output logic        in_reset,
   output cmd_pulse_t  pulse_q
);

   logic [15:0] cmd_n;
   cmd_pulse_t  pulse_n;

   always_comb begin
      cmd_n   = cmd_q;
      pulse_n = '0;
      if (wr) begin
         if (cmd_q[CB_SRST] && !wd[CB_SRST]) begin
            cmd_n[CB_SRST] = 1'b0;
         end else begin
            cmd_n = cmd_q | (wd & CMD_WMASK);
            if (wd[CB_RXOFF])  cmd_n[CB_RXON]   = 1'b0;
            if (wd[CB_RXON])   cmd_n[CB_RXOFF]  = 1'b0;
            if (wd[CB_TSTOP])  cmd_n[CB_TSTART] = 1'b0;
            if (wd[CB_TSTART]) cmd_n[CB_TSTOP]  = 1'b0;
            if (wd[CB_SRST]) begin
               cmd_n[CB_CAMLD]  = 1'b0;
               cmd_n[CB_RFETCH] = 1'b0;
               cmd_n[CB_TX]     = 1'b0;
               cmd_n[CB_HALT]   = 1'b0;
               cmd_n[CB_SRST]   = 1'b1;
               cmd_n[CB_RXOFF]  = 1'b1;
            end
            cmd_n[CB_RFETCH] = 1'b0;
            pulse_n.tx     = wd[CB_TX];
            pulse_n.camld  = wd[CB_CAMLD];
            pulse_n.rfetch = wd[CB_RFETCH];
            pulse_n.tstart = wd[CB_TSTART];
            pulse_n.tstop  = wd[CB_TSTOP];
         end
      end
      if (tx_done)  cmd_n[CB_TX]    = 1'b0;
      if (cam_done) cmd_n[CB_CAMLD] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= CMD_RSTVAL;
         pulse_q <= '0;
      end else begin
         cmd_q   <= cmd_n;
         pulse_q <= pulse_n;
      end
   end

   assign in_reset = cmd_q[CB_SRST];

endmodule

// File: rtl/nrf_irq_unit.sv
module nrf_irq_unit
   import nrf_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mask,
   input  logic              wr_stat,
   input  logic [DATA_W-1:0] wd,
   input  logic [DATA_W-1:0] status_set,
   output logic [DATA_W-1:0] imr_q,
   output logic [DATA_W-1:0] isr_q,
   output logic              irq,
   output logic              bufex_go_q
);

   logic [DATA_W-1:0] clr;
   logic [DATA_W-1:0] imr_n;
   logic [DATA_W-1:0] isr_n;

   always_comb begin
      clr   = wr_stat ? (wd & isr_q) : '0;
      isr_n = (isr_q & ~clr) | status_set;
      imr_n = wr_mask ? (wd & IMR_WMASK) : imr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr_q      <= '0;
         isr_q      <= '0;
         bufex_go_q <= 1'b0;
      end else begin
         imr_q      <= imr_n;
         isr_q      <= isr_n;
         bufex_go_q <= clr[IS_BUFEX];
      end
   end

   assign irq = |(imr_q & isr_q);

endmodule

// File: rtl/nrf_store.sv
module nrf_store
   import nrf_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wd,
   input  logic                          in_reset,
   output logic [(1<<ADDR_W)-1:0][DATA_W-1:0] q
);

   localparam int NREG = 1 << ADDR_W;

   logic wide;
   assign wide = q[ADR_DCFG][DCFG_WIDE];

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      if (held_elsewhere(i)) begin : g_hole
         assign q[i] = '0;
      end else begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[i] <= slot_reset(i);
            else if (wr_en && (addr == ADDR_W'(i)))
               q[i] <= slot_write(i, q[i], wd, in_reset, wide);
         end
      end
   end

endmodule

// File: rtl/nrf_regbank.sv
module nrf_regbank
   import nrf_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 16,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] status_set,
   input  logic              tx_done,
   input  logic              cam_done,
   output logic              irq,
   output logic              tx_go,
   output logic              cam_load_go,
   output logic              rsrc_fetch_go,
   output logic              timer_start_go,
   output logic              timer_stop_go
);

   localparam int NREG = 1 << ADDR_W;

   if (DATA_W != 16) begin : g_bad_width
      $error("nrf_regbank: DATA_W must be 16");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("nrf_regbank: ADDR_W must be at least 6");
   end

   logic hit_cmd, hit_mask, hit_stat;
   assign hit_cmd  = wr_en && (addr == ADDR_W'(ADR_CMD));
   assign hit_mask = wr_en && (addr == ADDR_W'(ADR_IMASK));
   assign hit_stat = wr_en && (addr == ADDR_W'(ADR_ISTAT));

   logic [15:0] cmd_q;
   logic        in_reset;
   cmd_pulse_t  pulse_q;

   nrf_cmd_unit u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (hit_cmd),
      .wd       (wdata),
      .tx_done  (tx_done),
      .cam_done (cam_done),
      .cmd_q    (cmd_q),
      .in_reset (in_reset),
      .pulse_q  (pulse_q)
   );

   logic [DATA_W-1:0] imr_q, isr_q;
   logic              bufex_go_q;

   nrf_irq_unit #(.DATA_W(DATA_W)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_mask    (hit_mask),
      .wr_stat    (hit_stat),
      .wd         (wdata),
      .status_set (status_set),
      .imr_q      (imr_q),
      .isr_q      (isr_q),
      .irq        (irq),
      .bufex_go_q (bufex_go_q)
   );

   logic [NREG-1:0][DATA_W-1:0] store_q;

   nrf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wd       (wdata),
      .in_reset (in_reset),
      .q        (store_q)
   );

   assign tx_go          = pulse_q.tx;
   assign cam_load_go    = pulse_q.camld;
   assign rsrc_fetch_go  = pulse_q.rfetch | bufex_go_q;
   assign timer_start_go = pulse_q.tstart;
   assign timer_stop_go  = pulse_q.tstop;

   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      if (addr == ADDR_W'(ADR_CMD))        rd_mux = cmd_q;
      else if (addr == ADDR_W'(ADR_IMASK)) rd_mux = imr_q;
      else if (addr == ADDR_W'(ADR_ISTAT)) rd_mux = isr_q;
      else                                 rd_mux = store_q[addr];
   end

   if (READ_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= rd_en ? rd_mux : '0;
      end
   end else begin : g_rd_comb
      assign rdata = rd_en ? rd_mux : '0;
   end

endmodule

// File: rtl/nrf_regbank_chk.sv
module nrf_regbank_chk
   import nrf_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [15:0]       wdata,
   input logic [15:0]       status_set,
   input logic [15:0]       cmd_q,
   input logic [15:0]       imr_q,
   input logic [15:0]       isr_q,
   input logic [15:0]       dcfg_q,
   input logic [15:0]       rev_q,
   input logic              irq,
   input logic              tx_go,
   input logic              rsrc_fetch_go
);

   // R3
   rst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(ADR_CMD) && cmd_q[CB_SRST] && !wdata[CB_SRST])
      |=> (!cmd_q[CB_SRST] && !tx_go));

   // R2
   tx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go |-> $past(wr_en && addr == ADDR_W'(ADR_CMD) && wdata[CB_TX]));

   // R6
   cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(ADR_DCFG) && !cmd_q[CB_SRST]) |=> $stable(dcfg_q));

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_set != 16'h0) |=> ((isr_q & $past(status_set)) == $past(status_set)));

   // R9
   bufex_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(ADR_ISTAT) && wdata[IS_BUFEX] && isr_q[IS_BUFEX])
      |=> rsrc_fetch_go);

   // R10
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((status_set & imr_q) != 16'h0) && !(wr_en && addr == ADDR_W'(ADR_IMASK)))
      |=> irq);

   // R13
   rev_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(ADR_REV)) |=> $stable(rev_q));

endmodule

bind nrf_regbank nrf_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .addr          (addr),
   .wdata         (wdata),
   .status_set    (status_set),
   .cmd_q         (cmd_q),
   .imr_q         (imr_q),
   .isr_q         (isr_q),
   .dcfg_q        (store_q[nrf_pkg::ADR_DCFG]),
   .rev_q         (store_q[nrf_pkg::ADR_REV]),
   .irq           (irq),
   .tx_go         (tx_go),
   .rsrc_fetch_go (rsrc_fetch_go)
);

// File: tb/nrf_regbank_test.sv
`timescale 1ns/1ps
module nrf_regbank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [15:0] status_set = '0;
   logic        tx_done = 1'b0;
   logic        cam_done = 1'b0;
   logic        irq, tx_go, cam_load_go, rsrc_fetch_go, timer_start_go, timer_stop_go;

   always #4 clk = ~clk;

   nrf_regbank uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .status_set(status_set),
      .tx_done(tx_done), .cam_done(cam_done), .irq(irq), .tx_go(tx_go),
      .cam_load_go(cam_load_go), .rsrc_fetch_go(rsrc_fetch_go),
      .timer_start_go(timer_start_go), .timer_stop_go(timer_stop_go));

   int m [64];
   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic check(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      foreach (m[i]) m[i] = 0;
      m['h00] = 'h0094;
      m['h02] = 'h0020;
      m['h03] = 'h0101;
      m['h13] = 'h02F8;
      m['h28] = 'h0004;
   endtask

   // one clock: drive, update model, compare strobes and irq after the edge
   task automatic step(int a, bit we, int wd, int ss, bit txd, bit camd, string tag);
      int c, exp_out, act_out;
      int ptx = 0, pcam = 0, prf = 0, pts = 0, ptp = 0;
      @(negedge clk);
      rd_en = 0; addr = 6'(a); wr_en = we; wdata = 16'(wd);
      status_set = 16'(ss); tx_done = txd; cam_done = camd;
      c = m[0];
      if (we) begin
         case (a)
            'h00: begin
               if ((c & 'h80) != 0 && (wd & 'h80) == 0) c &= ~'h80;
               else begin
                  c |= wd & 'h3BF;
                  if (wd & 'h4)  c &= ~'h8;
                  if (wd & 'h8)  c &= ~'h4;
                  if (wd & 'h10) c &= ~'h20;
                  if (wd & 'h20) c &= ~'h10;
                  if (wd & 'h80) begin c &= ~'h303; c |= 'h84; end
                  c &= ~'h100;
                  ptx = (wd >> 1) & 1; pcam = (wd >> 9) & 1; prf = (wd >> 8) & 1;
                  pts = (wd >> 5) & 1; ptp = (wd >> 4) & 1;
               end
            end
            'h01: if (m[0] & 'h80) m[1] = wd & 'hBFFF;
            'h3F: if (m[0] & 'h80) m['h3F] = wd & 'hF017;
            'h02: m[2] = wd & 'hFFE0;
            'h03: m[3] = wd & 'hF000;
            'h04: m[4] = wd & 'h7FFF;
            'h05: begin
               int cl;
               cl = wd & m[5];
               if (cl & 'h20) prf = 1;
               m[5] &= ~cl;
            end
            'h15, 'h16, 'h17, 'h18: m[a] = (m[1] & 'h20) ? (wd & 'hFFFC) : (wd & 'hFFFE);
            'h2C, 'h2D, 'h2E: m[a] = ~wd & 'hFFFF;
            'h22, 'h23, 'h24, 'h28, 'h2F: ;
            default: m[a] = wd & 'hFFFF;
         endcase
      end
      m[5] |= ss & 'hFFFF;
      if (txd)  c &= ~'h2;
      if (camd) c &= ~'h200;
      m[0] = c;
      exp_out = (((m[4] & m[5]) != 0) << 5) | (ptx << 4) | (pcam << 3) | (prf << 2) | (pts << 1) | ptp;
      @(posedge clk);
      #2;
      act_out = {26'b0, irq, tx_go, cam_load_go, rsrc_fetch_go, timer_start_go, timer_stop_go};
      check({tag, " strobes/irq"}, act_out, exp_out);
   endtask

   task automatic rd(int a, string tag);
      @(negedge clk);
      wr_en = 0; rd_en = 1; addr = 6'(a); status_set = 0; tx_done = 0; cam_done = 0;
      #1;
      check($sformatf("%s read 0x%0h", tag, a), int'(rdata), m[a]);
      rd_en = 0;
   endtask

   task automatic wr(int a, int wd, string tag);
      step(a, 1, wd, 0, 0, 0, tag);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state of every register
      for (int i = 0; i < 64; i++) rd(i, "R1");
      check("R1 irq", int'(irq), 0);

      // R6 configuration writes in reset mode, wide mode selected
      wr('h01, 'hFFFF, "R6"); rd('h01, "R6");
      wr('h3F, 'hFFFF, "R6"); rd('h3F, "R6");
      // R12 wide alignment
      wr('h15, 'h1237, "R12"); rd('h15, "R12");
      // R3 leave reset mode, no strobes although bits are set
      wr('h00, 'h0322, "R3"); rd('h00, "R3");
      // R6 dropped outside reset
      wr('h01, 'h0000, "R6"); rd('h01, "R6");
      wr('h3F, 'h0000, "R6"); rd('h3F, "R6");
      wr('h16, 'hFFFF, "R12"); rd('h16, "R12");
      // R7 masks
      wr('h03, 'hFFFF, "R7"); rd('h03, "R7");
      wr('h02, 'hFFFF, "R7"); rd('h02, "R7");
      wr('h04, 'hFFFF, "R7"); rd('h04, "R7");
      wr('h04, 'h0000, "R7");
      // R11 tallies
      wr('h2C, 'h1234, "R11"); rd('h2C, "R11");
      wr('h2D, 'h0000, "R11"); rd('h2D, "R11");
      wr('h2E, 'hF0F0, "R11"); rd('h2E, "R11");
      // R13 read-only
      wr('h28, 'hFFFF, "R13"); rd('h28, "R13");
      wr('h22, 'hFFFF, "R13"); rd('h22, "R13");
      wr('h24, 'hFFFF, "R13"); rd('h24, "R13");
      wr('h2F, 'hFFFF, "R13"); rd('h2F, "R13");
      // R2 and R14 transmit
      wr('h00, 'h0002, "R2"); rd('h00, "R2");
      step('h00, 0, 0, 0, 1, 0, "R14"); rd('h00, "R14");
      // R5 mutual clears
      wr('h00, 'h0008, "R5"); rd('h00, "R5");
      wr('h00, 'h0004, "R5"); rd('h00, "R5");
      wr('h00, 'h0020, "R5"); rd('h00, "R5");
      wr('h00, 'h0010, "R5"); rd('h00, "R5");
      wr('h00, 'h000C, "R5"); rd('h00, "R5");
      // R2 resource fetch and filter load
      wr('h00, 'h0100, "R2"); rd('h00, "R2");
      wr('h00, 'h0200, "R2"); rd('h00, "R2");
      step('h00, 1, 'h0002, 0, 0, 1, "R14"); rd('h00, "R14");
      step('h00, 1, 'h0000, 0, 1, 0, "R14"); rd('h00, "R14");
      // R4 soft reset
      wr('h00, 'h0201, "R4"); rd('h00, "R4");
      wr('h00, 'h0082, "R4"); rd('h00, "R4");
      // R12 narrow mode: clear width bit while in reset, then leave
      wr('h01, 'h0000, "R12"); wr('h00, 'h0000, "R3");
      wr('h17, 'hFFFF, "R12"); rd('h17, "R12");
      wr('h18, 'h0003, "R12"); rd('h18, "R12");
      // R8 R9 R10 interrupt path
      wr('h04, 'h00FF, "R10");
      step('h00, 0, 0, 'h0021, 0, 0, "R10"); rd('h05, "R8");
      wr('h05, 'h0020, "R9"); rd('h05, "R9");
      step('h05, 1, 'h0001, 'h0001, 0, 0, "R8"); rd('h05, "R8");
      wr('h05, 'h0001, "R10"); rd('h05, "R8");
      wr('h05, 'h0020, "R9");
      step('h00, 0, 0, 'h0100, 0, 0, "R10");
      wr('h04, 'h0100, "R10");
      wr('h05, 'hFFFF, "R8"); rd('h05, "R8");

      // random traffic for all requirements
      for (int k = 0; k < 3000; k++) begin
         int a, ss;
         a = $urandom_range(0, 63);
         if ($urandom_range(0, 3) == 0) a = $urandom_range(0, 5);
         ss = ($urandom_range(0, 7) == 0) ? ($urandom & 'hFFFF) : 0;
         step(a, $urandom_range(0, 1), $urandom & 'hFFFF, ss,
              $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0, "R2 random");
         rd($urandom_range(0, 63), "R13 random");
      end
      summary();
   end

endmodule